// File: doc/BRIEF.md
# Time-Sliced Output Serializer with Write Latency

This block turns one wide parallel word per core cycle into a bit stream on a group of output pins. The word holds a number of time slices, each slice carrying one bit for every pin. A matching output-enable word, laid out the same way, travels beside the data and becomes a per-pin enable. The block runs on the fast bit clock. It counts out each core cycle with an internal phase counter and raises a frame strobe in the bit-clock cycle whose closing edge takes the next core word.

A write latency setting delays the whole stream, data and enable together, by a whole number of core cycles, from zero up to a parameter limit. In double-rate mode each bit-clock cycle carries two slices. They appear on a rising-edge lane and a falling-edge lane, which feed a double-rate output register at the pad. In single-rate mode the two lanes carry the same slice. With 8 slices and double rate the block serves a quarter-rate core. With 4 slices it serves half rate.

Top module: `slice_serializer`

## Requirements
- R1: While reset is high, and for the first bit-clock cycle after it falls, all output-enable lanes are 0 and the frame strobe is 0.
- R2: The frame strobe is first seen high SLICES/2 - 1 bit-clock cycles after reset is released (3 cycles at the defaults). It is then high for exactly one cycle in every SLICES/2 cycles, and its closing edge captures `core_data_i`, `core_oe_i` and `wr_lat_i`.
- R3: Slices leave in ascending order starting with slice 0. In double-rate mode, bit-clock cycle k after a load shows slice 2k on the rising lanes and slice 2k+1 on the falling lanes.
- R4: Within a slice s, pin p takes bus bit s*PINS + p, so pin 0 is the least significant bit of the slice.
- R5: The output-enable bus uses the same slice and pin positions as the data bus. An enable lane is 1 exactly when its delayed enable bit is 1. Data lanes are only defined while their enable lane is 1.
- R6: With a write latency of L, the word captured at frame strobe f goes out during the core cycle that follows capture edge f+L. With L = 0, its slices 0 and 1 show in the bit-clock cycle right after its own capture edge.
- R7: After reset, all enable lanes stay 0 until a word captured after reset has passed through the latency pipeline. With latency L, the output for the first L frames has enables at 0 whatever `core_oe_i` held.
- R8: A latency setting above MAX_LAT acts as MAX_LAT (a setting of 6 or 7 acts as 5 at the defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous active-high reset |
| core_data_i | input | PINS*SLICES | Data word, slice-major, pin 0 in the LSB of each slice |
| core_oe_i | input | PINS*SLICES | Output-enable word, same layout as the data word |
| wr_lat_i | input | LAT_W | Write latency in core cycles |
| frame_o | output | 1 | High in the bit-clock cycle whose closing edge takes the next core word |
| pin_d_rise_o | output | PINS | Per-pin data for the rising edge |
| pin_d_fall_o | output | PINS | Per-pin data for the falling edge |
| pin_oe_rise_o | output | PINS | Per-pin enable for the rising edge |
| pin_oe_fall_o | output | PINS | Per-pin enable for the falling edge |

## Verification
A word is presented in the cycle where the frame strobe is high. Its group k (slices 2k and 2k+1) is due in the k-th bit-clock cycle after capture edge f+L, where one register stage separates the capture edge from the lanes. The bench drives on falling edges and samples every lane on the falling edge that follows each rising edge. It computes the expected group from its own log of all words driven since reset, indexed by frame number minus the clamped latency. Frames whose index would fall before reset are expected to have every enable low.

// File: rtl/ser_pkg.sv
package ser_pkg;
  // slices carried per bit-clock cycle
  function automatic int per_cycle(input bit ddr);
    return ddr ? 2 : 1;
  endfunction

  // counter width able to hold values 0..n-1 (at least one bit)
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ser_phase.sv
module ser_phase #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = ser_pkg::cnt_width(CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;
  logic          tick_q;

  always_comb begin
    if (cnt_q == CW'(CYC - 1)) cnt_nx = '0;
    else                       cnt_nx = cnt_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= (CYC == 1);
    end else begin
      cnt_q  <= cnt_nx;
      tick_q <= (cnt_nx == CW'(CYC - 1));
    end
  end

  assign tick_o = tick_q;

  generate
    if (CYC > 1) begin : g_chk
      // R2: one strobe cycle per frame, never two in a row
      a_r2_single_tick: assert property (@(posedge clk) disable iff (rst)
        tick_q |=> !tick_q);
    end
  endgenerate
endmodule

// File: rtl/ser_lat_line.sv
module ser_lat_line #(
  parameter int W       = 64,
  parameter int MAX_LAT = 5,
  parameter int LAT_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  input  logic [W-1:0]     word_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic [W-1:0]     word_o,
  output logic             valid_o
);
  localparam int DEPTH = (MAX_LAT > 0) ? MAX_LAT : 1;

  logic [W-1:0]     stage_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [LAT_W-1:0] eff_lat;

  // data stages: no reset, plain shift so the tools may map them to memory
  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
      if (k == 0) begin : g_head
        always_ff @(posedge clk) if (adv_i) stage_q[0] <= word_i;
      end else begin : g_body
        always_ff @(posedge clk) if (adv_i) stage_q[k] <= stage_q[k-1];
        // R7: stages fill in order from the input side
        a_r7_fill_order: assert property (@(posedge clk) disable iff (rst)
          vld_q[k] |-> vld_q[k-1]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (adv_i) begin
      vld_q[0] <= 1'b1;
      for (int k = 1; k < DEPTH; k++) vld_q[k] <= vld_q[k-1];
    end
  end

  always_comb begin
    if (lat_i > LAT_W'(MAX_LAT)) eff_lat = LAT_W'(MAX_LAT);
    else                         eff_lat = lat_i;
  end

  always_comb begin
    if (eff_lat == '0 || MAX_LAT == 0) begin
      word_o  = word_i;
      valid_o = 1'b1;
    end else begin
      word_o  = stage_q[int'(eff_lat) - 1];
      valid_o = vld_q[int'(eff_lat) - 1];
    end
  end
endmodule

// File: rtl/ser_slicer.sv
module ser_slicer #(
  parameter int PINS   = 4,
  parameter int SLICES = 8,
  parameter int PER    = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load_i,
  input  logic [PINS*SLICES-1:0] data_i,
  input  logic [PINS*SLICES-1:0] oe_i,
  input  logic                   valid_i,
  output logic [PINS-1:0]        rise_d_o,
  output logic [PINS-1:0]        fall_d_o,
  output logic [PINS-1:0]        rise_oe_o,
  output logic [PINS-1:0]        fall_oe_o
);
  localparam int BUS = PINS * SLICES;
  localparam int GW  = PINS * PER;

  logic [BUS-1:0]  d_sr_q, oe_sr_q;
  logic            vld_q;
  logic [GW-1:0]   grp_d, grp_oe;
  logic            grp_v;
  logic [PINS-1:0] rise_d_q, fall_d_q, rise_oe_q, fall_oe_q;

  always_comb begin
    if (load_i) begin
      grp_d  = data_i[GW-1:0];
      grp_oe = oe_i[GW-1:0];
      grp_v  = valid_i;
    end else begin
      grp_d  = d_sr_q[GW-1:0];
      grp_oe = oe_sr_q[GW-1:0];
      grp_v  = vld_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d_sr_q    <= '0;
      oe_sr_q   <= '0;
      vld_q     <= 1'b0;
      rise_d_q  <= '0;
      fall_d_q  <= '0;
      rise_oe_q <= '0;
      fall_oe_q <= '0;
    end else begin
      if (load_i) begin
        d_sr_q  <= data_i >> GW;
        oe_sr_q <= oe_i >> GW;
        vld_q   <= valid_i;
      end else begin
        d_sr_q  <= d_sr_q >> GW;
        oe_sr_q <= oe_sr_q >> GW;
      end
      rise_d_q  <= grp_d[PINS-1:0];
      fall_d_q  <= grp_d[GW-1:GW-PINS];
      rise_oe_q <= grp_oe[PINS-1:0] & {PINS{grp_v}};
      fall_oe_q <= grp_oe[GW-1:GW-PINS] & {PINS{grp_v}};
    end
  end

  assign rise_d_o  = rise_d_q;
  assign fall_d_o  = fall_d_q;
  assign rise_oe_o = rise_oe_q;
  assign fall_oe_o = fall_oe_q;

  // R3: the cycle after a load shows slice 0 of the loaded word
  a_r3_first_slice: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(load_i)) |-> (rise_d_q == $past(data_i[PINS-1:0])));
endmodule

// File: rtl/slice_serializer.sv
module slice_serializer #(
  parameter int PINS     = 4,
  parameter int SLICES   = 8,
  parameter bit DDR_MODE = 1'b1,
  parameter int MAX_LAT  = 5,
  parameter int LAT_W    = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PINS*SLICES-1:0] core_data_i,
  input  logic [PINS*SLICES-1:0] core_oe_i,
  input  logic [LAT_W-1:0]       wr_lat_i,
  output logic                   frame_o,
  output logic [PINS-1:0]        pin_d_rise_o,
  output logic [PINS-1:0]        pin_d_fall_o,
  output logic [PINS-1:0]        pin_oe_rise_o,
  output logic [PINS-1:0]        pin_oe_fall_o
);
  localparam int PER = ser_pkg::per_cycle(DDR_MODE);
  localparam int CYC = SLICES / PER;
  localparam int BUS = PINS * SLICES;

  logic           tick;
  logic [BUS-1:0] dl_data, dl_oe;
  logic           dl_valid;

  ser_phase #(.CYC(CYC)) phase_i (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  ser_lat_line #(.W(2*BUS), .MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) line_i (
    .clk     (clk),
    .rst     (rst),
    .adv_i   (tick),
    .word_i  ({core_oe_i, core_data_i}),
    .lat_i   (wr_lat_i),
    .word_o  ({dl_oe, dl_data}),
    .valid_o (dl_valid)
  );

  ser_slicer #(.PINS(PINS), .SLICES(SLICES), .PER(PER)) slicer_i (
    .clk       (clk),
    .rst       (rst),
    .load_i    (tick),
    .data_i    (dl_data),
    .oe_i      (dl_oe),
    .valid_i   (dl_valid),
    .rise_d_o  (pin_d_rise_o),
    .fall_d_o  (pin_d_fall_o),
    .rise_oe_o (pin_oe_rise_o),
    .fall_oe_o (pin_oe_fall_o)
  );

  assign frame_o = tick;

  // R1: leaving reset, every enable lane is still low
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe_rise_o == '0 && pin_oe_fall_o == '0));
endmodule

// File: tb/slice_serializer_tb_top.sv
module slice_serializer_tb_top;
  localparam int PINS    = 4;
  localparam int SLICES  = 8;
  localparam int MAX_LAT = 5;
  localparam int LAT_W   = 3;
  localparam int CYC     = SLICES / 2;
  localparam int BUS     = PINS * SLICES;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [BUS-1:0]   core_data = '0;
  logic [BUS-1:0]   core_oe = '0;
  logic [LAT_W-1:0] wr_lat = '0;
  logic             frame;
  logic [PINS-1:0]  d_r, d_f, oe_r, oe_f;

  int n_chk = 0;
  int n_bad = 0;
  int g = 0;
  logic [BUS-1:0] hist_d  [512];
  logic [BUS-1:0] hist_oe [512];

  always #2.5 clk = ~clk;

  slice_serializer #(.PINS(PINS), .SLICES(SLICES), .DDR_MODE(1'b1),
                     .MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) dut_i (
    .clk(clk), .rst(rst), .core_data_i(core_data), .core_oe_i(core_oe),
    .wr_lat_i(wr_lat), .frame_o(frame), .pin_d_rise_o(d_r),
    .pin_d_fall_o(d_f), .pin_oe_rise_o(oe_r), .pin_oe_fall_o(oe_f));

  task automatic check_bit(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s frame strobe got=%0b exp=%0b (frame %0d)", tag, got, exp, g);
    end
  endtask

  task automatic check_group(input string tag, input int leff, input int k);
    logic [PINS-1:0] er, ef, eor, eof, mr, mf;
    int e;
    e = g - leff;
    er = '0; ef = '0; eor = '0; eof = '0;
    if (e >= 0) begin
      for (int p = 0; p < PINS; p++) begin
        er[p]  = hist_d[e][(2*k)*PINS + p];
        ef[p]  = hist_d[e][(2*k+1)*PINS + p];
        eor[p] = hist_oe[e][(2*k)*PINS + p];
        eof[p] = hist_oe[e][(2*k+1)*PINS + p];
      end
    end
    mr = eor; mf = eof;
    n_chk++;
    if (oe_r !== eor || oe_f !== eof || (d_r & mr) !== (er & mr) ||
        (d_f & mf) !== (ef & mf)) begin
      n_bad++;
      $display("FAIL %s frame %0d group %0d: got d=%h/%h oe=%h/%h exp d=%h/%h oe=%h/%h",
               tag, g, k, d_r, d_f, oe_r, oe_f, er & mr, ef & mf, eor, eof);
    end
  endtask

  // kind: 0 random data, enables on; 1 walking data bit; 2 walking enable bit
  task automatic run_frames(input string tag, input int nf, input int lat, input int kind);
    int leff;
    string t;
    leff = (lat > MAX_LAT) ? MAX_LAT : lat;
    for (int f = 0; f < nf; f++) begin
      while (!frame) @(negedge clk);
      wr_lat = LAT_W'(lat);
      for (int i = 0; i < BUS; i++) core_data[i] = 1'($urandom_range(0, 1));
      core_oe = '1;
      if (kind == 1) core_data = BUS'(1) << (f % BUS);
      if (kind == 2) core_oe = BUS'(1) << (f % BUS);
      hist_d[g]  = core_data;
      hist_oe[g] = core_oe;
      t = (g - leff < 0) ? "R7" : tag;
      for (int k = 0; k < CYC; k++) begin
        @(negedge clk);
        check_group(t, leff, k);
        check_bit("R2", frame, (k == CYC - 1));
      end
      g++;
    end
  endtask

  task automatic t_reset;
    int waited;
    rst = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check_bit("R1", frame, 1'b0);
      check_bit("R1", |{oe_r, oe_f}, 1'b0);
    end
    rst = 1'b0;
    waited = 0;
    while (!frame && waited < 20) begin
      check_bit("R1", |{oe_r, oe_f}, 1'b0);
      @(negedge clk);
      waited++;
    end
    n_chk++;
    if (waited != CYC - 1) begin
      n_bad++;
      $display("FAIL R2 first strobe after %0d cycles, expected %0d", waited, CYC - 1);
    end
  endtask

  task automatic t_lat3_fill;     run_frames("R6", 8, 3, 0);      endtask
  task automatic t_slice_order;   run_frames("R3 R4", BUS, 0, 1); endtask
  task automatic t_oe_layout;     run_frames("R5", BUS, 0, 2);    endtask
  task automatic t_lat_sweep;
    for (int l = 1; l <= MAX_LAT; l++) run_frames("R6", 8, l, 0);
  endtask
  task automatic t_clamp;
    run_frames("R8", 10, 7, 0);
    run_frames("R8", 6, 6, 2);
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_lat3_fill();
    t_slice_order();
    t_oe_layout();
    t_lat_sweep();
    t_clamp();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule